// File: doc/BRIEF.md
# Transmit Descriptor Queue Engine

This block drains transmit queues made of linked descriptors in shared memory. Software builds a chain of four-word descriptors. Each descriptor points at a byte buffer and carries the routing fields of one outgoing message: destination, priority, transport type, mailbox, port and length. Software hands each descriptor over by setting its ownership bit, then starts the queue by writing the address of the first descriptor into that queue's head pointer register. The engine fetches the descriptor, streams the buffer out one byte per handshake with the routing fields held alongside, and returns the descriptor. To return it, the engine rewrites the control word with ownership cleared, records the descriptor address in the queue's completion pointer register and pulses a completion strobe.

A queue stops in one of two ways. When a descriptor whose next pointer is zero has been sent, the engine also sets the end-of-queue bit in that descriptor. When the engine meets a descriptor that software has not handed over, it sends nothing from it. In both cases the queue's head pointer register is cleared. Any number of queues may be active at once. Before each message the engine picks the lowest-numbered active queue, so a low-numbered queue can take over between two messages of a higher-numbered one. A head pointer write to a queue that is still running is dropped and raises a per-queue error flag.

The engine is a single state machine with these states:
- IDLE: pick a queue.
- FREQ and FCAP: request and capture the four descriptor words.
- CHECK: test ownership.
- BREQ and BCAP: request and capture one buffer word.
- BOUT: offer bytes.
- WB: write the control word back.
- DONE: report completion and advance the queue.

Transitions:
- IDLE→FREQ when any queue is active.
- FREQ→FCAP always.
- FCAP→FREQ while words remain, FCAP→CHECK after the fourth word.
- CHECK→BREQ when owned, CHECK→IDLE when not owned.
- BREQ→BCAP and BCAP→BOUT always.
- BOUT→BREQ after the fourth byte of a word is accepted, BOUT→WB after the final byte is accepted.
- WB→DONE and DONE→IDLE always.

Top module: `txq_engine`

## Requirements
- R1: After reset every queue is inactive, every head pointer, completion pointer and error flag reads 0, and neither a stream byte nor a completion is offered.
- R2: Register select 0 is the head pointer. A non-zero write to an inactive queue makes it active and starts fetching at that word address. A zero write leaves the queue inactive. Reading select 3 returns the active flag in bit 0.
- R3: A descriptor occupies four consecutive words starting at its address:
  - word 0: next-descriptor address;
  - word 1: buffer address;
  - word 2, the control word: bit 31 ownership, bit 30 end-of-queue, bits 29:28 transport type, bits 27:26 priority, bits 25:24 port, bits 23:20 mailbox, bits 15:0 destination;
  - word 3: message length minus one, in bits 11:0.

  These fields appear on the stream header outputs, with m_len giving the byte count, for every byte of the message.
- R4: Buffer bytes leave in order, with byte k taken from word k/4 of the buffer at bit offset 8·(k mod 4). A byte transfers when m_valid and m_ready are both high. m_last marks only the final byte. While m_ready is low, m_valid, m_data, m_last and the header outputs hold.
- R5: A descriptor whose ownership bit is 0 is neither sent nor rewritten and raises no completion. Its queue becomes inactive and its head pointer reads 0.
- R6: After the last byte of a message, the engine rewrites the control word with ownership 0 and end-of-queue set exactly when the next address is 0. All other control bits are unchanged.
- R7: For each message sent, done_valid is high for one cycle, with the queue number, the descriptor address and the end-of-queue value. The queue's completion pointer (select 1) then reads that descriptor address.
- R8: A non-zero next address makes the engine continue at that descriptor; the head pointer reads it meanwhile. A zero next address makes the queue inactive with a head pointer of 0.
- R9: Before each message the lowest-numbered active queue is chosen. A message, once started, completes before another queue is served.
- R10: A head pointer write to an active queue does not change its head pointer and sets its error flag (select 2, bit 0). Any write to select 2 clears that flag. CPU writes to select 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_sel | input | 2 | Register select: 0 head, 1 completion, 2 error, 3 active |
| cpu_q | input | QW | Queue number for access |
| cpu_wdata | input | AW | Write data |
| cpu_rdata | output | AW | Read data for cpu_sel/cpu_q (combinational) |
| q_active | output | NQ | Per-queue active flags |
| busy_err | output | NQ | Per-queue error flags |
| mem_rd | output | 1 | Memory read request; data returns next cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| m_valid | output | 1 | Stream byte valid |
| m_ready | input | 1 | Stream byte accepted |
| m_data | output | 8 | Stream byte |
| m_last | output | 1 | Final byte of message |
| m_dest | output | 16 | Destination field |
| m_prio | output | 2 | Priority field |
| m_tt | output | 2 | Transport type field |
| m_mbox | output | 4 | Mailbox field |
| m_port | output | 2 | Port field |
| m_len | output | LEN_W+1 | Message byte count |
| done_valid | output | 1 | Completion strobe |
| done_q | output | QW | Completed queue |
| done_addr | output | AW | Completed descriptor address |
| done_eoq | output | 1 | Completion ended the queue |

## Verification
The bench sends a one-byte message, a message that ends partway through a buffer word, and a chain sent under an irregular ready pattern. A design that miscounted bytes or dropped a byte on a stall would either place the last flag wrongly or corrupt the byte order. It tests an unowned head descriptor and an unowned second descriptor; an engine that ignored ownership would emit bytes, rewrite memory or keep the queue alive. While one queue is stalled in the middle of a message, it starts two lower-numbered queues and rewrites the stalled queue's head pointer. A wrong arbiter would show up as an out-of-order completion sequence, and a missing busy guard would show up as a changed head pointer with no error flag.

// File: rtl/txq_pkg.sv
package txq_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FREQ,
        S_FCAP,
        S_CHECK,
        S_BREQ,
        S_BCAP,
        S_BOUT,
        S_WB,
        S_DONE
    } eng_state_t;

    typedef enum logic [1:0] {
        SEL_HEAD = 2'd0,
        SEL_COMP = 2'd1,
        SEL_ERR  = 2'd2,
        SEL_ACT  = 2'd3
    } reg_sel_t;

    // control word of a descriptor, most significant field first
    typedef struct packed {
        logic        own;
        logic        eoq;
        logic [1:0]  tt;
        logic [1:0]  prio;
        logic [1:0]  port;
        logic [3:0]  mbox;
        logic [3:0]  spare;
        logic [15:0] dest;
    } ctrl_word_t;

endpackage

// File: rtl/txq_pick.sv
module txq_pick #(
    parameter int NQ = 16,
    parameter int QW = $clog2(NQ)
) (
    input  logic [NQ-1:0] req,
    output logic          any,
    output logic [QW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = NQ - 1; i >= 0; i--) begin
            if (req[i]) idx = QW'(i);
        end
    end
endmodule

// File: rtl/txq_regs.sv
module txq_regs
    import txq_pkg::*;
#(
    parameter int NQ = 16,
    parameter int QW = $clog2(NQ),
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_wr,
    input  logic [1:0]    cpu_sel,
    input  logic [QW-1:0] cpu_q,
    input  logic [AW-1:0] cpu_wdata,
    output logic [AW-1:0] cpu_rdata,
    input  logic          eng_stop,
    input  logic          eng_adv,
    input  logic [QW-1:0] eng_q,
    input  logic [AW-1:0] eng_next,
    input  logic [AW-1:0] eng_cp,
    output logic [AW-1:0] head [NQ],
    output logic [NQ-1:0] act,
    output logic [NQ-1:0] err
);
    logic [AW-1:0] comp [NQ];

    for (genvar g = 0; g < NQ; g++) begin : g_q
        logic [AW-1:0] head_r, comp_r;
        logic          act_r, err_r;
        logic          hit;

        assign hit = cpu_wr && (cpu_q == QW'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                head_r <= '0;
                comp_r <= '0;
                act_r  <= 1'b0;
                err_r  <= 1'b0;
            end else begin
                if (eng_stop && eng_q == QW'(g)) begin
                    head_r <= '0;
                    act_r  <= 1'b0;
                end else if (eng_adv && eng_q == QW'(g)) begin
                    comp_r <= eng_cp;
                    head_r <= eng_next;
                    act_r  <= (eng_next != '0);
                end else if (hit && cpu_sel == SEL_HEAD && !act_r && cpu_wdata != '0) begin
                    head_r <= cpu_wdata;
                    act_r  <= 1'b1;
                end
                if (hit && cpu_sel == SEL_HEAD && act_r) begin
                    err_r <= 1'b1;
                end else if (hit && cpu_sel == SEL_ERR) begin
                    err_r <= 1'b0;
                end
            end
        end

        assign head[g] = head_r;
        assign comp[g] = comp_r;
        assign act[g]  = act_r;
        assign err[g]  = err_r;
    end

    always_comb begin
        unique case (cpu_sel)
            SEL_HEAD: cpu_rdata = head[cpu_q];
            SEL_COMP: cpu_rdata = comp[cpu_q];
            SEL_ERR:  cpu_rdata = AW'(err[cpu_q]);
            default:  cpu_rdata = AW'(act[cpu_q]);
        endcase
    end
endmodule

// File: rtl/txq_fsm.sv
module txq_fsm
    import txq_pkg::*;
#(
    parameter int QW    = 4,
    parameter int AW    = 16,
    parameter int LEN_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              any_req,
    input  logic [QW-1:0]     pick_q,
    input  logic [AW-1:0]     pick_head,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [AW-1:0]     mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [7:0]        m_data,
    output logic              m_last,
    output logic [15:0]       m_dest,
    output logic [1:0]        m_prio,
    output logic [1:0]        m_tt,
    output logic [3:0]        m_mbox,
    output logic [1:0]        m_port,
    output logic [LEN_W:0]    m_len,
    output logic              eng_stop,
    output logic              eng_adv,
    output logic [QW-1:0]     eng_q,
    output logic [AW-1:0]     eng_next,
    output logic [AW-1:0]     eng_cp,
    output logic              done_valid,
    output logic [QW-1:0]     done_q,
    output logic [AW-1:0]     done_addr,
    output logic              done_eoq
);
    eng_state_t       state, nstate;
    logic [QW-1:0]    cur_q;
    logic [AW-1:0]    d_addr, d_next, d_buf;
    ctrl_word_t       d_ctrl, ctrl_back;
    logic [LEN_W-1:0] d_lenm1, bcnt;
    logic [1:0]       fcnt;
    logic [DATA_W-1:0] word;
    logic             is_last, at_end;

    assign is_last = (bcnt == d_lenm1);
    assign at_end  = (d_next == '0);

    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE:  if (any_req) nstate = S_FREQ;
            S_FREQ:  nstate = S_FCAP;
            S_FCAP:  nstate = (fcnt == 2'd3) ? S_CHECK : S_FREQ;
            S_CHECK: nstate = d_ctrl.own ? S_BREQ : S_IDLE;
            S_BREQ:  nstate = S_BCAP;
            S_BCAP:  nstate = S_BOUT;
            S_BOUT: begin
                if (m_ready) begin
                    if (is_last)                nstate = S_WB;
                    else if (bcnt[1:0] == 2'd3) nstate = S_BREQ;
                end
            end
            S_WB:    nstate = S_DONE;
            S_DONE:  nstate = S_IDLE;
            default: nstate = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            cur_q   <= '0;
            d_addr  <= '0;
            d_next  <= '0;
            d_buf   <= '0;
            d_ctrl  <= '0;
            d_lenm1 <= '0;
            bcnt    <= '0;
            fcnt    <= '0;
            word    <= '0;
        end else begin
            state <= nstate;
            unique case (state)
                S_IDLE: begin
                    if (any_req) begin
                        cur_q  <= pick_q;
                        d_addr <= pick_head;
                        fcnt   <= '0;
                    end
                end
                S_FCAP: begin
                    unique case (fcnt)
                        2'd0:    d_next  <= mem_rdata[AW-1:0];
                        2'd1:    d_buf   <= mem_rdata[AW-1:0];
                        2'd2:    d_ctrl  <= mem_rdata;
                        default: d_lenm1 <= mem_rdata[LEN_W-1:0];
                    endcase
                    fcnt <= fcnt + 2'd1;
                end
                S_CHECK: bcnt <= '0;
                S_BCAP:  word <= mem_rdata;
                S_BOUT: begin
                    if (m_ready && !is_last) bcnt <= bcnt + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        ctrl_back     = d_ctrl;
        ctrl_back.own = 1'b0;
        ctrl_back.eoq = at_end;
    end

    always_comb begin
        mem_rd     = 1'b0;
        mem_wr     = 1'b0;
        mem_addr   = d_addr;
        mem_wdata  = ctrl_back;
        m_valid    = 1'b0;
        eng_stop   = 1'b0;
        eng_adv    = 1'b0;
        done_valid = 1'b0;
        unique case (state)
            S_FREQ: begin
                mem_rd   = 1'b1;
                mem_addr = d_addr + AW'(fcnt);
            end
            S_CHECK: eng_stop = !d_ctrl.own;
            S_BREQ: begin
                mem_rd   = 1'b1;
                mem_addr = d_buf + AW'(bcnt >> 2);
            end
            S_BOUT: m_valid = 1'b1;
            S_WB: begin
                mem_wr   = 1'b1;
                mem_addr = d_addr + AW'(2);
            end
            S_DONE: begin
                eng_adv    = 1'b1;
                done_valid = 1'b1;
            end
            default: ;
        endcase
    end

    assign m_data    = word[8*bcnt[1:0] +: 8];
    assign m_last    = is_last;
    assign m_dest    = d_ctrl.dest;
    assign m_prio    = d_ctrl.prio;
    assign m_tt      = d_ctrl.tt;
    assign m_mbox    = d_ctrl.mbox;
    assign m_port    = d_ctrl.port;
    assign m_len     = {1'b0, d_lenm1} + 1'b1;
    assign eng_q     = cur_q;
    assign eng_next  = d_next;
    assign eng_cp    = d_addr;
    assign done_q    = cur_q;
    assign done_addr = d_addr;
    assign done_eoq  = at_end;
endmodule

// File: rtl/txq_engine.sv
module txq_engine #(
    parameter int NQ    = 16,
    parameter int AW    = 16,
    parameter int LEN_W = 12,
    localparam int QW   = $clog2(NQ)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_wr,
    input  logic [1:0]       cpu_sel,
    input  logic [QW-1:0]    cpu_q,
    input  logic [AW-1:0]    cpu_wdata,
    output logic [AW-1:0]    cpu_rdata,
    output logic [NQ-1:0]    q_active,
    output logic [NQ-1:0]    busy_err,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic [AW-1:0]    mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic [31:0]      mem_rdata,
    output logic             m_valid,
    input  logic             m_ready,
    output logic [7:0]       m_data,
    output logic             m_last,
    output logic [15:0]      m_dest,
    output logic [1:0]       m_prio,
    output logic [1:0]       m_tt,
    output logic [3:0]       m_mbox,
    output logic [1:0]       m_port,
    output logic [LEN_W:0]   m_len,
    output logic             done_valid,
    output logic [QW-1:0]    done_q,
    output logic [AW-1:0]    done_addr,
    output logic             done_eoq
);
    logic [AW-1:0] head [NQ];
    logic          any_req;
    logic [QW-1:0] pick_q, eng_q;
    logic          eng_stop, eng_adv;
    logic [AW-1:0] eng_next, eng_cp;

    txq_pick #(.NQ(NQ), .QW(QW)) u_pick (
        .req (q_active),
        .any (any_req),
        .idx (pick_q)
    );

    txq_regs #(.NQ(NQ), .QW(QW), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_wr    (cpu_wr),
        .cpu_sel   (cpu_sel),
        .cpu_q     (cpu_q),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .eng_stop  (eng_stop),
        .eng_adv   (eng_adv),
        .eng_q     (eng_q),
        .eng_next  (eng_next),
        .eng_cp    (eng_cp),
        .head      (head),
        .act       (q_active),
        .err       (busy_err)
    );

    txq_fsm #(.QW(QW), .AW(AW), .LEN_W(LEN_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_req    (any_req),
        .pick_q     (pick_q),
        .pick_head  (head[pick_q]),
        .mem_rd     (mem_rd),
        .mem_wr     (mem_wr),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .m_valid    (m_valid),
        .m_ready    (m_ready),
        .m_data     (m_data),
        .m_last     (m_last),
        .m_dest     (m_dest),
        .m_prio     (m_prio),
        .m_tt       (m_tt),
        .m_mbox     (m_mbox),
        .m_port     (m_port),
        .m_len      (m_len),
        .eng_stop   (eng_stop),
        .eng_adv    (eng_adv),
        .eng_q      (eng_q),
        .eng_next   (eng_next),
        .eng_cp     (eng_cp),
        .done_valid (done_valid),
        .done_q     (done_q),
        .done_addr  (done_addr),
        .done_eoq   (done_eoq)
    );
endmodule

// File: rtl/txq_engine_chk.sv
module txq_engine_chk #(
    parameter int NQ = 16,
    parameter int AW = 16,
    localparam int QW = $clog2(NQ)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_wr,
    input logic [1:0]    cpu_sel,
    input logic [QW-1:0] cpu_q,
    input logic [NQ-1:0] q_active,
    input logic [NQ-1:0] busy_err,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic          m_valid,
    input logic          m_ready,
    input logic [7:0]    m_data,
    input logic          m_last,
    input logic [15:0]   m_dest,
    input logic          done_valid,
    input logic [QW-1:0] done_q,
    input logic          done_eoq
);
    assert_stream_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_last) && $stable(m_dest));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    assert_queue_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid && done_eoq |=> !q_active[$past(done_q)]);

    assert_busy_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr && cpu_sel == 2'd0 && q_active[cpu_q] |=> busy_err[$past(cpu_q)]);

    assert_mem_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_serving_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> (q_active != '0));
endmodule

bind txq_engine txq_engine_chk #(.NQ(NQ), .AW(AW)) u_chk (.*);

// File: tb/txq_engine_test.sv
module txq_engine_test;
    localparam int NQ = 16, AW = 16, LEN_W = 12, QW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic cpu_wr = 1'b0;
    logic [1:0] cpu_sel = 2'd0;
    logic [QW-1:0] cpu_q = '0;
    logic [AW-1:0] cpu_wdata = '0;
    logic [AW-1:0] cpu_rdata;
    logic [NQ-1:0] q_active, busy_err;
    logic mem_rd, mem_wr;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic m_valid, m_ready, m_last;
    logic [7:0] m_data;
    logic [15:0] m_dest;
    logic [1:0] m_prio, m_tt, m_port;
    logic [3:0] m_mbox;
    logic [LEN_W:0] m_len;
    logic done_valid, done_eoq;
    logic [QW-1:0] done_q;
    logic [AW-1:0] done_addr;

    txq_engine #(.NQ(NQ), .AW(AW), .LEN_W(LEN_W)) uut (.*);

    logic [31:0] mem [0:1023];
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
        if (mem_wr) mem[mem_addr[9:0]] = mem_wdata;
    end

    int nchk = 0, nfail = 0;
    int cyc = 0, stall_mode = 0;
    int nb = 0, nd = 0;
    logic [7:0]  lg_data [0:511];
    logic        lg_last [0:511];
    logic [25:0] lg_hdr  [0:511];
    logic [12:0] lg_len  [0:511];
    logic [3:0]  dq [0:31];
    logic [15:0] da [0:31];
    logic        de [0:31];

    always @(negedge clk) begin
        cyc++;
        case (stall_mode)
            0:       m_ready = 1'b1;
            1:       m_ready = (cyc % 3) != 0;
            default: m_ready = 1'b0;
        endcase
        if (m_valid && m_ready && nb < 512) begin
            lg_data[nb] = m_data;
            lg_last[nb] = m_last;
            lg_hdr[nb]  = {m_dest, m_prio, m_tt, m_mbox, m_port};
            lg_len[nb]  = m_len;
            nb++;
        end
        if (done_valid && nd < 32) begin
            dq[nd] = done_q; da[nd] = done_addr; de[nd] = done_eoq;
            nd++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [1:0] sel, input int q, input logic [AW-1:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_sel = sel; cpu_q = QW'(q); cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(input logic [1:0] sel, input int q, output logic [AW-1:0] d);
        @(negedge clk);
        cpu_sel = sel; cpu_q = QW'(q);
        #1 d = cpu_rdata;
    endtask

    function automatic logic [31:0] mk_ctrl(input bit own, input logic [1:0] tt,
            input logic [1:0] pri, input logic [1:0] port, input logic [3:0] mbox,
            input logic [15:0] dest);
        return {own, 1'b0, tt, pri, port, mbox, 4'h0, dest};
    endfunction

    function automatic logic [25:0] hdr_of(input logic [31:0] c);
        return {c[15:0], c[27:26], c[29:28], c[23:20], c[25:24]};
    endfunction

    task automatic make_desc(input int a, input int nxt, input int buff,
                             input logic [31:0] ctrl, input int len, input logic [7:0] seed);
        mem[a] = nxt; mem[a+1] = buff; mem[a+2] = ctrl; mem[a+3] = len - 1;
        for (int k = 0; k < len; k++) mem[buff + k/4][8*(k%4) +: 8] = seed + 8'(k*7);
    endtask

    task automatic check_msg(input int base, input int len, input logic [7:0] seed,
                             input logic [31:0] ctrl, input string req);
        bit ok_d = 1, ok_l = 1, ok_h = 1;
        for (int k = 0; k < len; k++) begin
            if (lg_data[base+k] !== seed + 8'(k*7)) ok_d = 0;
            if (lg_last[base+k] !== (k == len - 1)) ok_l = 0;
            if (lg_hdr[base+k] !== hdr_of(ctrl) || lg_len[base+k] !== 13'(len)) ok_h = 0;
        end
        chk(ok_d, req, "byte order", {24'h0, lg_data[base]}, {24'h0, seed});
        chk(ok_l, req, "last flag", {31'h0, lg_last[base+len-1]}, 1);
        chk(ok_h, "R3", "header fields", {6'h0, lg_hdr[base]}, {6'h0, hdr_of(ctrl)});
    endtask

    task automatic wait_done(input int n);
        int t = 0;
        while (nd < n && t < 3000) begin @(negedge clk); t++; end
        chk(nd >= n, "R7", "completion count", nd, n);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [AW-1:0] v;
        cpu_read(2'd0, 0, v);  chk(v == 0, "R1", "head q0", v, 0);
        cpu_read(2'd1, 15, v); chk(v == 0, "R1", "comp q15", v, 0);
        chk(q_active == 0 && busy_err == 0, "R1", "flags", {q_active, busy_err}, 0);
        chk(!m_valid && !done_valid, "R1", "outputs idle", {m_valid, done_valid}, 0);
    endtask

    task automatic t_zero_write();
        logic [AW-1:0] v;
        int b0 = nb;
        cpu_write(2'd0, 4, 16'h0);
        repeat (10) @(negedge clk);
        cpu_read(2'd3, 4, v);
        chk(v == 0 && nb == b0, "R2", "zero head write stays idle", v, 0);
    endtask

    task automatic t_single();
        logic [AW-1:0] v;
        logic [31:0] c = mk_ctrl(1, 2'd2, 2'd3, 2'd1, 4'd9, 16'hBEEF);
        int b0 = nb, d0 = nd;
        make_desc(16'h100, 0, 16'h200, c, 6, 8'h11);
        cpu_write(2'd0, 3, 16'h100);
        cpu_read(2'd3, 3, v);
        chk(v == 1, "R2", "queue active after head write", v, 1);
        wait_done(d0 + 1);
        chk(nb - b0 == 6, "R4", "byte count", nb - b0, 6);
        check_msg(b0, 6, 8'h11, c, "R4");
        chk(mem[16'h102] == ((c & ~32'h8000_0000) | 32'h4000_0000), "R6", "control writeback",
            mem[16'h102], (c & ~32'h8000_0000) | 32'h4000_0000);
        chk(dq[d0] == 3 && da[d0] == 16'h100 && de[d0] == 1, "R7", "completion info",
            {dq[d0], da[d0], 3'b0, de[d0]}, {4'd3, 16'h100, 4'd1});
        cpu_read(2'd1, 3, v); chk(v == 16'h100, "R7", "completion pointer", v, 16'h100);
        cpu_read(2'd0, 3, v); chk(v == 0, "R8", "head cleared", v, 0);
        cpu_read(2'd3, 3, v); chk(v == 0, "R8", "queue inactive", v, 0);
        cpu_write(2'd1, 3, 16'h55);
        cpu_read(2'd1, 3, v); chk(v == 16'h100, "R10", "cpu completion write ignored", v, 16'h100);
    endtask

    task automatic t_chain_stall();
        logic [AW-1:0] v;
        logic [31:0] c0 = mk_ctrl(1, 2'd1, 2'd0, 2'd2, 4'd3, 16'h0042);
        logic [31:0] c1 = mk_ctrl(1, 2'd0, 2'd1, 2'd0, 4'd7, 16'h1234);
        logic [31:0] c2 = mk_ctrl(1, 2'd3, 2'd2, 2'd3, 4'd15, 16'hFFFF);
        int b0 = nb, d0 = nd;
        make_desc(16'h140, 16'h150, 16'h210, c0, 1, 8'hA0);
        make_desc(16'h150, 16'h160, 16'h220, c1, 4, 8'h30);
        make_desc(16'h160, 0,       16'h230, c2, 5, 8'h5C);
        stall_mode = 1;
        cpu_write(2'd0, 5, 16'h140);
        wait_done(d0 + 3);
        stall_mode = 0;
        chk(nb - b0 == 10, "R4", "chain byte count", nb - b0, 10);
        check_msg(b0, 1, 8'hA0, c0, "R4");
        check_msg(b0 + 1, 4, 8'h30, c1, "R8");
        check_msg(b0 + 5, 5, 8'h5C, c2, "R4");
        chk(de[d0] == 0 && de[d0+1] == 0 && de[d0+2] == 1, "R6", "eoq only at end",
            {de[d0], de[d0+1], de[d0+2]}, 3'b001);
        chk(mem[16'h152] == (c1 & ~32'h8000_0000), "R6", "middle writeback",
            mem[16'h152], c1 & ~32'h8000_0000);
        chk(da[d0+1] == 16'h150 && da[d0+2] == 16'h160, "R8", "follows next pointer",
            {da[d0+1], da[d0+2]}, {16'h150, 16'h160});
        cpu_read(2'd0, 5, v); chk(v == 0, "R8", "head cleared after chain", v, 0);
    endtask

    task automatic t_unowned();
        logic [AW-1:0] v;
        logic [31:0] cn = mk_ctrl(0, 2'd1, 2'd1, 2'd1, 4'd1, 16'h7777);
        logic [31:0] cy = mk_ctrl(1, 2'd2, 2'd0, 2'd0, 4'd2, 16'h0101);
        int b0 = nb, d0 = nd;
        make_desc(16'h180, 0, 16'h240, cn, 3, 8'h01);
        cpu_write(2'd0, 6, 16'h180);
        repeat (30) @(negedge clk);
        chk(nb == b0 && nd == d0, "R5", "unowned head sends nothing", nb - b0 + nd - d0, 0);
        chk(mem[16'h182] == cn, "R5", "unowned descriptor untouched", mem[16'h182], cn);
        cpu_read(2'd3, 6, v); chk(v == 0, "R5", "queue inactive", v, 0);
        cpu_read(2'd0, 6, v); chk(v == 0, "R5", "head cleared", v, 0);
        make_desc(16'h190, 16'h1A0, 16'h250, cy, 2, 8'h77);
        make_desc(16'h1A0, 0,       16'h260, cn, 2, 8'h88);
        cpu_write(2'd0, 6, 16'h190);
        wait_done(d0 + 1);
        repeat (30) @(negedge clk);
        chk(nd == d0 + 1 && nb == b0 + 2, "R5", "stops at unowned second", nd - d0, 1);
        chk(de[d0] == 0 && mem[16'h192] == (cy & ~32'h8000_0000), "R6", "first writeback no eoq",
            mem[16'h192], cy & ~32'h8000_0000);
        chk(mem[16'h1A2] == cn, "R5", "second untouched", mem[16'h1A2], cn);
        cpu_read(2'd0, 6, v); chk(v == 0, "R5", "head cleared after stop", v, 0);
    endtask

    task automatic t_priority_busy();
        logic [AW-1:0] v;
        logic [31:0] c = mk_ctrl(1, 2'd0, 2'd0, 2'd0, 4'd4, 16'h0009);
        int d0 = nd;
        make_desc(16'h1C0, 0,       16'h270, c, 8, 8'h40);
        make_desc(16'h1D0, 16'h1E0, 16'h280, c, 2, 8'h50);
        make_desc(16'h1E0, 0,       16'h290, c, 1, 8'h60);
        make_desc(16'h1F0, 0,       16'h2A0, c, 3, 8'h70);
        stall_mode = 2;
        cpu_write(2'd0, 9, 16'h1C0);
        repeat (20) @(negedge clk);
        cpu_write(2'd0, 7, 16'h1D0);
        cpu_write(2'd0, 2, 16'h1F0);
        cpu_write(2'd0, 9, 16'h300);
        cpu_read(2'd2, 9, v); chk(v == 1, "R10", "busy error flag", v, 1);
        cpu_read(2'd0, 9, v); chk(v == 16'h1C0, "R10", "busy write ignored", v, 16'h1C0);
        cpu_write(2'd2, 9, 16'h0);
        cpu_read(2'd2, 9, v); chk(v == 0, "R10", "error cleared", v, 0);
        chk(nd == d0, "R9", "stalled message not finished", nd - d0, 0);
        stall_mode = 0;
        wait_done(d0 + 4);
        chk(dq[d0] == 9 && dq[d0+1] == 2 && dq[d0+2] == 7 && dq[d0+3] == 7, "R9",
            "service order", {dq[d0], dq[d0+1], dq[d0+2], dq[d0+3]}, 16'h9277);
        chk(da[d0+2] == 16'h1D0 && da[d0+3] == 16'h1E0, "R9", "chain order kept",
            {da[d0+2], da[d0+3]}, {16'h1D0, 16'h1E0});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero_write();
        t_single();
        t_chain_stall();
        t_unowned();
        t_priority_busy();
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        nchk++;
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule